// File: doc/BRIEF.md
# Two-Stage Interval Interrupt Timer

This block is an interrupt timer clocked by the CPU clock. A wide low counter advances by one on every enabled CPU cycle. A small high counter steps down by one each time the low counter's phase field (its lowest `PHASE_W` bits) reaches the middle of its range. The interrupt line is raised after a counted cycle that leaves the high counter at zero while the phase field sits in its lower half. Once raised, the line stays high until software clears it.

Software controls the timer with write cycles into a fixed address window (upper address nibble equal to 0xF with the default parameters). Only address bits 1:0 select the action inside that window. Sub-address 0 stops the timer. Sub-address 1 starts it. Sub-address 3 loads the high counter. Sub-address 2 does nothing. The banking logic that shares the window and the CPU's interrupt controller are outside this block.

Top module: `vt_interval_timer`

## Requirements
- R1: After reset the interrupt output is 0, both counters are 0 and counting is disabled. With no write, the interrupt stays 0 for any number of cycles.
- R2: A write with address bits 1:0 = 0 inside the window lowers the interrupt, disables counting and zeroes the low counter. The high counter keeps its value.
- R3: A write with address bits 1:0 = 1 inside the window enables counting from the next cycle on. It does not lower a pending interrupt.
- R4: A write with address bits 1:0 = 3 inside the window loads the high counter with write-data bits 7:4 (HI_LSB = 4, HI_W = 4).
- R5: While counting is enabled and no stop write is present, the low counter rises by exactly one per clock.
- R6: The high counter steps down by one in the counted cycle whose increment makes the phase field equal to 2^(PHASE_W-1). A load in the same cycle takes precedence.
- R7: After a counted cycle that leaves the high counter at zero and the phase field below 2^(PHASE_W-1), the interrupt is 1. It then stays 1 until an R2 write. Starting from a low counter of 0 and a high value H, the interrupt therefore rises after 1 counted cycle when H = 0, and after H*2^PHASE_W counted cycles otherwise.
- R8: Writes with address bits 1:0 = 2, and writes whose upper address bits fall outside the window, change no state and do not interrupt counting.
- R9: Stepping down from zero wraps the high counter to its maximum value (15 for HI_W = 4).
- R10: Inside the window, address bits between the window field and bit 1 are ignored, so every mirror of a sub-address behaves the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; one count per rising edge while enabled |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| irq | output | 1 | Sticky interrupt request, active high |

## Verification
A write takes effect at the clock edge on which it is presented. A start write therefore makes the following edge the first counted cycle. The interrupt is a registered output and moves at the same edge as the counted cycle that causes it. The bench drives and samples on falling edges, so each falling edge after a start write corresponds to exactly one counted cycle. It checks the interrupt one falling edge before the computed count and again exactly at it (H*2^PHASE_W, or 1 for H = 0). When an ignored write is issued in the middle of a run, the bench counts both of its clock edges as counted cycles.

// File: rtl/vt_timer_pkg.sv
package vt_timer_pkg;

   typedef enum logic [1:0] {
      SUB_STOP = 2'd0,
      SUB_GO   = 2'd1,
      SUB_NOP  = 2'd2,
      SUB_LOAD = 2'd3
   } vt_sub_e;

   typedef struct packed {
      logic stop;
      logic go;
      logic load;
   } vt_cmd_t;

endpackage

// File: rtl/vt_wr_decode.sv
module vt_wr_decode
   import vt_timer_pkg::*;
#(
   parameter int          ADDR_W  = 16,
   parameter int          WIN_W   = 4,
   parameter int unsigned WIN_VAL = 15
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   output vt_cmd_t           cmd
);

   logic    hit;
   vt_sub_e sub;

   initial begin
      assert (ADDR_W >= WIN_W + 2) else $error("address too narrow for window plus sub-address");
   end

   generate
      if (WIN_W == 0) begin : g_nowin
         assign hit = wr_en;
         logic unused_mid;
         assign unused_mid = ^wr_addr[ADDR_W-1:2];
      end else begin : g_win
         localparam logic [WIN_W-1:0] WIN_BITS = WIN_VAL[WIN_W-1:0];
         assign hit = wr_en && (wr_addr[ADDR_W-1 -: WIN_W] == WIN_BITS);
         if (ADDR_W > WIN_W + 2) begin : g_mid
            logic unused_mid;
            assign unused_mid = ^wr_addr[ADDR_W-WIN_W-1:2];
         end
      end
   endgenerate

   assign sub = vt_sub_e'(wr_addr[1:0]);

   always_comb begin
      cmd      = '0;
      cmd.stop = hit && (sub == SUB_STOP);
      cmd.go   = hit && (sub == SUB_GO);
      cmd.load = hit && (sub == SUB_LOAD);
   end

endmodule

// File: rtl/vt_phase_cnt.sv
module vt_phase_cnt #(
   parameter int LO_W    = 16,
   parameter int PHASE_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            zero,
   input  logic            step,
   output logic [LO_W-1:0] lo_q,
   output logic            mid_hit,
   output logic            low_half_next
);

   localparam logic [PHASE_W-1:0] MID = PHASE_W'(1) << (PHASE_W - 1);

   logic [LO_W-1:0]    lo_inc;
   logic [PHASE_W-1:0] ph_inc;

   initial begin
      assert (PHASE_W >= 2 && PHASE_W <= LO_W) else $error("phase field must fit the low counter");
   end

   assign lo_inc        = lo_q + LO_W'(1);
   assign ph_inc        = lo_inc[PHASE_W-1:0];
   assign mid_hit       = step && (ph_inc == MID);
   assign low_half_next = ph_inc < MID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lo_q <= '0;
      else if (zero) lo_q <= '0;
      else if (step) lo_q <= lo_inc;
   end

   // R5: one increment per enabled cycle
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !zero) |=> (lo_q == $past(lo_q) + LO_W'(1)));

   // R2: stop zeroes the low counter
   a_r2_lo_zero: assert property (@(posedge clk) disable iff (!rst_n)
      zero |=> (lo_q == '0));

endmodule

// File: rtl/vt_hi_cnt.sv
module vt_hi_cnt #(
   parameter int HI_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [HI_W-1:0] load_val,
   input  logic            dec,
   output logic [HI_W-1:0] hi_q,
   output logic            zero_next
);

   logic [HI_W-1:0] hi_d;

   always_comb begin
      hi_d = hi_q;
      if (load)     hi_d = load_val;
      else if (dec) hi_d = hi_q - HI_W'(1);
   end

   assign zero_next = (hi_d == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hi_q <= '0;
      else        hi_q <= hi_d;
   end

   // R4: load takes the supplied value
   a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (hi_q == $past(load_val)));

   // R9: stepping down from zero wraps to all ones
   a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && dec && hi_q == '0) |=> (hi_q == '1));

   // R6: without load or decrement the counter holds
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !dec) |=> $stable(hi_q));

endmodule

// File: rtl/vt_irq_flag.sv
module vt_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set,
   output logic irq_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   irq_q <= 1'b0;
      else if (clr) irq_q <= 1'b0;
      else if (set) irq_q <= 1'b1;
   end

   // R7: sticky until cleared
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr) |=> irq_q);

   // R2: clear lowers the request
   a_r2_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !irq_q);

endmodule

// File: rtl/vt_interval_timer.sv
module vt_interval_timer
   import vt_timer_pkg::*;
#(
   parameter int          ADDR_W  = 16,
   parameter int          DATA_W  = 8,
   parameter int          WIN_W   = 4,
   parameter int unsigned WIN_VAL = 15,
   parameter int          LO_W    = 16,
   parameter int          PHASE_W = 12,
   parameter int          HI_W    = 4,
   parameter int          HI_LSB  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              irq
);

   localparam int HI_MSB = HI_LSB + HI_W - 1;

   vt_cmd_t         cmd;
   logic            run_q;
   logic            step;
   logic [LO_W-1:0] lo_q;
   logic            mid_hit;
   logic            low_half_next;
   logic [HI_W-1:0] hi_q;
   logic            hi_zero_next;
   logic            irq_set;
   logic            unused_data;

   initial begin
      assert (HI_W >= 1 && HI_MSB < DATA_W) else $error("high-counter field must fit the data bus");
   end

   generate
      if (DATA_W > HI_MSB + 1 && HI_LSB > 0) begin : g_dboth
         assign unused_data = ^{wr_data[DATA_W-1:HI_MSB+1], wr_data[HI_LSB-1:0]};
      end else if (DATA_W > HI_MSB + 1) begin : g_dtop
         assign unused_data = ^wr_data[DATA_W-1:HI_MSB+1];
      end else if (HI_LSB > 0) begin : g_dlow
         assign unused_data = ^wr_data[HI_LSB-1:0];
      end else begin : g_dnone
         assign unused_data = 1'b0;
      end
   endgenerate

   vt_wr_decode #(
      .ADDR_W (ADDR_W),
      .WIN_W  (WIN_W),
      .WIN_VAL(WIN_VAL)
   ) u_dec (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .cmd    (cmd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        run_q <= 1'b0;
      else if (cmd.stop) run_q <= 1'b0;
      else if (cmd.go)   run_q <= 1'b1;
   end

   assign step = run_q && !cmd.stop;

   vt_phase_cnt #(
      .LO_W   (LO_W),
      .PHASE_W(PHASE_W)
   ) u_lo (
      .clk          (clk),
      .rst_n        (rst_n),
      .zero         (cmd.stop),
      .step         (step),
      .lo_q         (lo_q),
      .mid_hit      (mid_hit),
      .low_half_next(low_half_next)
   );

   vt_hi_cnt #(
      .HI_W(HI_W)
   ) u_hi (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cmd.load),
      .load_val (wr_data[HI_MSB:HI_LSB]),
      .dec      (mid_hit),
      .hi_q     (hi_q),
      .zero_next(hi_zero_next)
   );

   assign irq_set = step && hi_zero_next && low_half_next;

   vt_irq_flag u_irq (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (cmd.stop),
      .set  (irq_set),
      .irq_q(irq)
   );

   // R1/R8: with no run and no write, counters hold
   a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wr_en) |=> ($stable(lo_q) && $stable(hi_q)));

   // R3: a start write leaves the timer running
   a_r3_go: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.go && !cmd.stop) |=> run_q);

   // R2: a stop write halts counting
   a_r2_halt: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.stop |=> !run_q);

   // R8: writes that decode to nothing leave all state alone
   a_r8_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cmd.stop && !cmd.go && !cmd.load && !run_q) |=> ($stable(lo_q) && $stable(hi_q) && $stable(irq)));

   // R7: the request only rises on a counted cycle
   a_r7_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(run_q));

endmodule

// File: tb/sim_vt_interval_timer.sv
module sim_vt_interval_timer;

   localparam int CLK_PERIOD = 10;
   localparam int PHASE_W    = 6;
   localparam int PERIOD     = 1 << PHASE_W;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vt_interval_timer #(
      .ADDR_W(16), .DATA_W(8), .WIN_W(4), .WIN_VAL(15),
      .LO_W(16), .PHASE_W(PHASE_W), .HI_W(4), .HI_LSB(4)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
   );

   task automatic check(input string req, input logic exp);
      n_checks++;
      if (irq !== exp) begin
         n_fail++;
         $display("FAIL %s: irq=%b expected %b", req, irq, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic int due(input int h);
      return (h == 0) ? 1 : h * PERIOD;
   endfunction

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      check("R1 reset", 1'b0);
      idle(200);
      check("R1 idle without start", 1'b0);

      // R4 R5 R6 R7 R10: sweep every high value, mirrored addresses
      for (int h = 0; h < 16; h++) begin
         wr(16'hF000 | 16'(h << 6), 8'h00);
         wr(16'hF003 | 16'(h << 4), 8'(h << 4) | 8'h0A);
         wr(16'hFFF1 ^ 16'(h << 2), 8'h00);
         idle(due(h) - 1);
         check($sformatf("R7 H=%0d before due", h), 1'b0);
         idle(1);
         check($sformatf("R6 H=%0d at due", h), 1'b1);
      end

      // R2: stop keeps high value, zeroes low counter
      wr(16'hF000, 8'h00);
      check("R2 clear", 1'b0);
      wr(16'hF003, 8'h20);
      wr(16'hF001, 8'h00);
      idle(40);
      check("R6 mid-run one step down", 1'b0);
      wr(16'hF000, 8'h00);
      idle(20);
      check("R2 stopped stays low", 1'b0);
      wr(16'hF001, 8'h00);
      idle(PERIOD - 1);
      check("R2 high kept, before", 1'b0);
      idle(1);
      check("R2 high kept, at due", 1'b1);

      // R8: ignored sub-address and out-of-window writes
      wr(16'hF000, 8'h00);
      wr(16'hF003, 8'h30);
      wr(16'hE003, 8'h00);
      wr(16'hF002, 8'h00);
      wr(16'h7001, 8'h00);
      idle(10);
      check("R8 no start outside window", 1'b0);
      wr(16'hF001, 8'h00);
      idle(100);
      wr(16'hF002, 8'h00);
      idle(3 * PERIOD - 102 - 1);
      check("R8 ignored write, before", 1'b0);
      idle(1);
      check("R8 ignored write, at due", 1'b1);
      wr(16'hF002, 8'h00);
      check("R8 sub2 does not clear", 1'b1);

      // R9: wrap from zero, R3/R7 stickiness
      wr(16'hF000, 8'h00);
      wr(16'hF003, 8'h00);
      wr(16'hF001, 8'h00);
      idle(1);
      check("R7 H=0 immediate", 1'b1);
      idle(39);
      check("R7 sticky in upper half", 1'b1);
      wr(16'hF001, 8'h00);
      check("R3 start does not clear", 1'b1);
      wr(16'hF000, 8'h00);
      check("R2 clear after wrap", 1'b0);
      wr(16'hF001, 8'h00);
      idle(15 * PERIOD - 1);
      check("R9 wrapped high, before", 1'b0);
      idle(1);
      check("R9 wrapped high, at due", 1'b1);

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 150000; i++) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule